// File: doc/BRIEF.md
# Zero-Address Stack Execution Unit

This block executes a stream of already-decoded stack-machine instructions. Arithmetic instructions name no operands. Add, subtract, multiply and divide each take the two topmost entries of an internal register stack and replace them with one result. Only the two memory instructions carry an address. A push reads a data word from memory and places it on top of the stack. A pop takes the top entry off the stack and writes it to memory.

The unit connects to a single-port data memory through a request/ready handshake. While a memory access is open, the unit lowers `instr_ready`, so the instruction source stalls. Three sticky flags report stack overflow, stack underflow and division by zero. The current top-of-stack value and the stack depth are visible at the ports, so a caller can follow an evaluation step by step.

Top module: `stack_exec_unit`

## Requirements
- R1: After reset, `depth` is 0, `tos_value` is 0, all three flags are 0, `instr_ready` is 1 and `mem_req` is 0.
- R2: Opcode 0 (push) issues a read (`mem_req`=1, `mem_we`=0) at `instr_addr`. When `mem_ready` is seen, the word on `mem_rdata` becomes the new top and `depth` rises by one.
- R3: Opcode 1 (pop) issues a write (`mem_req`=1, `mem_we`=1) of the top entry to `instr_addr`. When `mem_ready` is seen, `depth` falls by one.
- R4: Opcodes 2, 3, 4 and 5 give next+top, next-top, next*top (low 16 bits) and next/top (unsigned quotient), all modulo 2^16. Here "top" is the top entry and "next" is the entry below it.
- R5: An arithmetic instruction lowers `depth` by one, writes its result to the new top, and leaves all deeper entries unchanged. The result is visible the cycle after acceptance.
- R6: A push when 8 entries are held makes no memory request and leaves the stack unchanged. It sets `ovf_flag`, which stays set until reset.
- R7: An arithmetic instruction with fewer than two entries, or a pop with none, makes no memory request and changes nothing. It sets `unf_flag`, which stays set until reset.
- R8: A divide whose top entry is 0 pushes 0xFFFF as its result and sets `dz_flag`, which stays set until reset.
- R9: `instr_ready` is low from the cycle after a push or pop is accepted until the cycle after `mem_ready` completes it. Meanwhile `mem_req`, `mem_addr` and `mem_we` hold steady, and an instruction presented while `instr_ready` is low is not taken.
- R10: The sequence push A, push B, mul, push A, push C, push B, mul, add, sub leaves A*B-(A+C*B) modulo 2^16 on top, with `depth` 1.
- R11: Opcodes 6 and 7 are accepted but change neither the stack nor the flags, and make no memory request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction present |
| instr_op | input | 3 | Opcode (see R2–R4, R11) |
| instr_addr | input | 8 | Memory address for push and pop |
| instr_ready | output | 1 | Unit can take an instruction |
| mem_req | output | 1 | Memory access open |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 8 | Memory word address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Memory completes the access this cycle |
| tos_value | output | 16 | Top entry, 0 when empty |
| depth | output | 4 | Number of held entries |
| ovf_flag | output | 1 | Sticky stack overflow |
| unf_flag | output | 1 | Sticky stack underflow |
| dz_flag | output | 1 | Sticky divide by zero |

## Verification
The bench targets operand order in subtract and divide. A design that swaps top and next would give 0x005B as 0xFFA5 and return a quotient of 0 where 14 is expected. Pushing a ninth entry and popping from an empty stack each test for off-by-one limits on the count. A design with such a limit wrong would corrupt an entry, issue a stray memory request, or fail to raise the flag.

An ADD is held on the instruction lines throughout a push. A unit that accepted it while busy would cut the depth short or raise underflow. A zero divisor has to give 0xFFFF, and the dz flag has to stay set through a later valid divide. Two full expression runs, one of which wraps negative, catch any mix-up of which entries are popped.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [2:0] {
    OP_PUSH = 3'd0,
    OP_POP  = 3'd1,
    OP_ADD  = 3'd2,
    OP_SUB  = 3'd3,
    OP_MUL  = 3'd4,
    OP_DIV  = 3'd5,
    OP_NOP6 = 3'd6,
    OP_NOP7 = 3'd7
  } stk_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_WRITE = 2'd2
  } stk_state_e;
endpackage

// File: rtl/stk_alu.sv
module stk_alu
  import stk_pkg::*;
#(
  parameter int W = 16
) (
  input  stk_op_e      op,
  input  logic [W-1:0] lhs,
  input  logic [W-1:0] rhs,
  output logic [W-1:0] result,
  output logic         div_zero
);
  always_comb begin
    div_zero = 1'b0;
    result   = '0;
    unique case (op)
      OP_ADD: result = lhs + rhs;
      OP_SUB: result = lhs - rhs;
      OP_MUL: result = lhs * rhs;
      OP_DIV: begin
        if (rhs == '0) begin
          div_zero = 1'b1;
          result   = '1;
        end else begin
          result = lhs / rhs;
        end
      end
      default: result = '0;
    endcase
  end
endmodule

// File: rtl/stk_store.sv
module stk_store #(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_en,
  input  logic [W-1:0]  push_data,
  input  logic          pop_en,
  input  logic          merge_en,
  input  logic [W-1:0]  merge_data,
  output logic [CW-1:0] count,
  output logic [W-1:0]  top,
  output logic [W-1:0]  next
);
  logic [W-1:0]  stk [DEPTH];
  logic [CW-1:0] count_q, count_d;
  logic [W-1:0]  wr_data;

  assign wr_data = push_en ? push_data : merge_data;

  always_comb begin
    count_d = count_q;
    if (push_en)                 count_d = count_q + CW'(1);
    else if (pop_en || merge_en) count_d = count_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              count_q <= '0;
    else if (push_en || pop_en || merge_en)  count_q <= count_d;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    logic wr_en;
    assign wr_en = (push_en && (count_q == CW'(i))) ||
                   (merge_en && (count_q == CW'(i + 2)));
    always_ff @(posedge clk) begin
      if (wr_en) stk[i] <= wr_data;
    end
  end

  always_comb begin
    top  = '0;
    next = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (count_q == CW'(i + 1)) top = stk[i];
      if ((i + 2 <= DEPTH) && (count_q == CW'(i + 2))) next = stk[i];
    end
  end

  assign count = count_q;

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CW'(DEPTH));
  p_push_grows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    push_en |=> (count_q == $past(count_q) + CW'(1)));
  p_merge_shrinks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    merge_en |=> (count_q == $past(count_q) - CW'(1)) && (top == $past(merge_data)));
endmodule

// File: rtl/stack_exec_unit.sv
module stack_exec_unit
  import stk_pkg::*;
#(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  parameter int AW    = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         instr_valid,
  input  logic [2:0]                   instr_op,
  input  logic [AW-1:0]                instr_addr,
  output logic                         instr_ready,
  output logic                         mem_req,
  output logic                         mem_we,
  output logic [AW-1:0]                mem_addr,
  output logic [W-1:0]                 mem_wdata,
  input  logic [W-1:0]                 mem_rdata,
  input  logic                         mem_ready,
  output logic [W-1:0]                 tos_value,
  output logic [$clog2(DEPTH+1)-1:0]   depth,
  output logic                         ovf_flag,
  output logic                         unf_flag,
  output logic                         dz_flag
);
  localparam int CW = $clog2(DEPTH + 1);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  stk_state_e    state_q, state_d;
  logic [AW-1:0] addr_q, addr_d;
  logic          ovf_q, ovf_d, unf_q, unf_d, dz_q, dz_d;

  stk_op_e       op;
  logic          accept, is_arith;
  logic          push_en, pop_en, merge_en;
  logic [CW-1:0] count;
  logic [W-1:0]  top, next, alu_res;
  logic          alu_dz;

  assign op       = stk_op_e'(instr_op);
  assign accept   = instr_valid && (state_q == ST_IDLE);
  assign is_arith = (op == OP_ADD) || (op == OP_SUB) || (op == OP_MUL) || (op == OP_DIV);

  stk_alu #(.W(W)) u_alu (
    .op       (op),
    .lhs      (next),
    .rhs      (top),
    .result   (alu_res),
    .div_zero (alu_dz)
  );

  stk_store #(.W(W), .DEPTH(DEPTH)) u_store (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .push_en    (push_en),
    .push_data  (mem_rdata),
    .pop_en     (pop_en),
    .merge_en   (merge_en),
    .merge_data (alu_res),
    .count      (count),
    .top        (top),
    .next       (next)
  );

  always_comb begin
    state_d  = state_q;
    addr_d   = addr_q;
    ovf_d    = ovf_q;
    unf_d    = unf_q;
    dz_d     = dz_q;
    push_en  = 1'b0;
    pop_en   = 1'b0;
    merge_en = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (op == OP_PUSH) begin
            if (count == CW'(DEPTH)) ovf_d = 1'b1;
            else begin
              state_d = ST_READ;
              addr_d  = instr_addr;
            end
          end else if (op == OP_POP) begin
            if (count == '0) unf_d = 1'b1;
            else begin
              state_d = ST_WRITE;
              addr_d  = instr_addr;
            end
          end else if (is_arith) begin
            if (count < CW'(2)) unf_d = 1'b1;
            else begin
              merge_en = 1'b1;
              if (alu_dz) dz_d = 1'b1;
            end
          end
        end
      end
      ST_READ: begin
        if (mem_ready) begin
          push_en = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_WRITE: begin
        if (mem_ready) begin
          pop_en  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      ovf_q   <= 1'b0;
      unf_q   <= 1'b0;
      dz_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) addr_q <= addr_d;
      ovf_q <= ovf_d;
      unf_q <= unf_d;
      dz_q  <= dz_d;
    end
  end

  assign instr_ready = (state_q == ST_IDLE) && rst_sync_n;
  assign mem_req     = (state_q != ST_IDLE);
  assign mem_we      = (state_q == ST_WRITE);
  assign mem_addr    = addr_q;
  assign mem_wdata   = top;
  assign tos_value   = top;
  assign depth       = count;
  assign ovf_flag    = ovf_q;
  assign unf_flag    = unf_q;
  assign dz_flag     = dz_q;

  p_ready_low_busy_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mem_req |-> !instr_ready);
  p_req_held_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
  p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ovf_flag |=> ovf_flag);
  p_full_push_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (instr_valid && instr_ready && op == OP_PUSH && depth == CW'(DEPTH))
      |=> (!mem_req && $stable(depth) && ovf_flag));
  p_short_arith_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (instr_valid && instr_ready && is_arith && depth < CW'(2))
      |=> ($stable(depth) && unf_flag && !mem_req));
  p_dz_allones_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (instr_valid && instr_ready && op == OP_DIV && depth >= CW'(2) && tos_value == '0)
      |=> (tos_value == '1 && dz_flag));
endmodule

// File: tb/stack_exec_unit_bench.sv
module stack_exec_unit_bench;
  logic        clk;
  logic        rst_n;
  logic        instr_valid;
  logic [2:0]  instr_op;
  logic [7:0]  instr_addr;
  logic        instr_ready;
  logic        mem_req, mem_we;
  logic [7:0]  mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic        mem_ready;
  logic [15:0] tos_value;
  logic [3:0]  depth;
  logic        ovf_flag, unf_flag, dz_flag;

  int n_checks = 0;
  int n_fails  = 0;
  int cyc      = 0;
  int wcnt     = 0;
  logic [15:0] bmem [16];

  localparam int LAT = 2;

  stack_exec_unit u_stack_exec_unit (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_op(instr_op),
    .instr_addr(instr_addr), .instr_ready(instr_ready), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready), .tos_value(tos_value),
    .depth(depth), .ovf_flag(ovf_flag), .unf_flag(unf_flag), .dz_flag(dz_flag)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // memory model: answers after LAT waiting cycles, acts at falling edges
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ready = 1'b0;
      wcnt = 0;
    end else if (mem_ready) begin
      mem_ready = 1'b0;
    end else if (mem_req) begin
      if (wcnt == LAT) begin
        mem_ready = 1'b1;
        if (mem_we) bmem[mem_addr[3:0]] = mem_wdata;
        else        mem_rdata = bmem[mem_addr[3:0]];
        wcnt = 0;
      end else begin
        wcnt++;
      end
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      n_fails++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected below 50000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    instr_valid = 1'b0;
    instr_op    = 3'd0;
    instr_addr  = 8'd0;
    rst_n       = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic issue(input logic [2:0] op, input logic [7:0] a);
    @(negedge clk);
    while (!instr_ready) @(negedge clk);
    instr_valid = 1'b1;
    instr_op    = op;
    instr_addr  = a;
    @(negedge clk);
    instr_valid = 1'b0;
    while (!instr_ready) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 depth", depth, 0);
    chk("R1 tos", tos_value, 0);
    chk("R1 flags", {ovf_flag, unf_flag, dz_flag}, 0);
    chk("R1 ready/req", {instr_ready, mem_req}, 2'b10);
  endtask

  task automatic t_push_pop();
    do_reset();
    issue(3'd0, 8'd3);
    chk("R2 push tos", tos_value, 16'd100);
    chk("R2 push depth", depth, 1);
    issue(3'd0, 8'd4);
    chk("R2 second push tos", tos_value, 16'd9);
    issue(3'd1, 8'd12);
    chk("R3 pop written", bmem[12], 16'd9);
    chk("R3 pop depth/tos", {depth, tos_value}, {4'd1, 16'd100});
    issue(3'd1, 8'd13);
    chk("R3 second pop written", bmem[13], 16'd100);
    chk("R3 empty", depth, 0);
  endtask

  task automatic t_arith();
    do_reset();
    issue(3'd0, 8'd0);   // 7
    issue(3'd0, 8'd3);   // 100
    issue(3'd0, 8'd4);   // 9
    issue(3'd3, 8'd0);   // 100-9
    chk("R4 sub next-top", tos_value, 16'd91);
    chk("R5 depth after sub", depth, 2);
    issue(3'd2, 8'd0);   // 7+91
    chk("R5 deeper entry kept, add", tos_value, 16'd98);
    chk("R5 depth after add", depth, 1);
    issue(3'd0, 8'd1);   // 5
    issue(3'd0, 8'd4);   // 9
    issue(3'd3, 8'd0);
    chk("R4 sub wraps", tos_value, 16'hFFFC);
    do_reset();
    issue(3'd0, 8'd5);
    issue(3'd0, 8'd5);
    issue(3'd4, 8'd0);
    chk("R4 mul low bits", tos_value, 16'd24464);
    do_reset();
    issue(3'd0, 8'd3);   // 100
    issue(3'd0, 8'd0);   // 7
    issue(3'd5, 8'd0);
    chk("R4 div next/top", tos_value, 16'd14);
    chk("R4 no dz", dz_flag, 0);
  endtask

  task automatic t_divzero();
    do_reset();
    issue(3'd0, 8'd3);   // 100
    issue(3'd0, 8'd6);   // 0
    issue(3'd5, 8'd0);
    chk("R8 result all ones", tos_value, 16'hFFFF);
    chk("R8 dz set, depth", {dz_flag, depth}, {1'b1, 4'd1});
    issue(3'd0, 8'd7);   // 2
    issue(3'd5, 8'd0);
    chk("R8 later div", tos_value, 16'h7FFF);
    chk("R8 dz sticky", dz_flag, 1);
  endtask

  task automatic t_overflow();
    do_reset();
    for (int i = 0; i < 8; i++) issue(3'd0, 8'(8 + i));
    chk("R6 full depth", depth, 8);
    chk("R6 no ovf yet", ovf_flag, 0);
    issue(3'd0, 8'd0);
    chk("R6 ovf set", ovf_flag, 1);
    chk("R6 stack unchanged", {depth, tos_value}, {4'd8, 16'd165});
    chk("R6 no request", mem_req, 0);
  endtask

  task automatic t_underflow();
    do_reset();
    issue(3'd1, 8'd14);
    chk("R7 empty pop flag", unf_flag, 1);
    chk("R7 empty pop no req", {mem_req, depth}, 0);
    do_reset();
    issue(3'd0, 8'd1);
    issue(3'd2, 8'd0);
    chk("R7 single-entry add flag", unf_flag, 1);
    chk("R7 single-entry unchanged", {depth, tos_value}, {4'd1, 16'd5});
  endtask

  task automatic t_ignored();
    do_reset();
    issue(3'd0, 8'd4);
    issue(3'd6, 8'd2);
    issue(3'd7, 8'd2);
    chk("R11 stack unchanged", {depth, tos_value}, {4'd1, 16'd9});
    chk("R11 flags/req", {ovf_flag, unf_flag, dz_flag, mem_req}, 0);
  endtask

  task automatic t_handshake();
    do_reset();
    issue(3'd0, 8'd0);   // 7
    @(negedge clk);
    instr_valid = 1'b1;
    instr_op    = 3'd0;
    instr_addr  = 8'd1;
    @(negedge clk);
    instr_op = 3'd2;     // ADD held while busy
    chk("R9 ready low", instr_ready, 0);
    chk("R9 read request", {mem_req, mem_we, mem_addr}, {1'b1, 1'b0, 8'd1});
    while (!instr_ready) @(negedge clk);
    instr_valid = 1'b0;
    chk("R9 held op not taken", {depth, unf_flag}, {4'd2, 1'b0});
    chk("R9 pushed word", tos_value, 16'd5);
    issue(3'd2, 8'd0);
    chk("R9 then add", tos_value, 16'd12);
  endtask

  task automatic t_expr(input logic [7:0] a, input logic [7:0] b,
                        input logic [7:0] c, input logic [15:0] exp);
    do_reset();
    issue(3'd0, a);
    issue(3'd0, b);
    issue(3'd4, 8'd0);
    issue(3'd0, a);
    issue(3'd0, c);
    issue(3'd0, b);
    issue(3'd4, 8'd0);
    issue(3'd2, 8'd0);
    issue(3'd3, 8'd0);
    chk("R10 expression", tos_value, exp);
    chk("R10 depth", depth, 1);
  endtask

  initial begin
    rst_n = 1'b0;
    mem_ready = 1'b0;
    mem_rdata = '0;
    instr_valid = 1'b0;
    instr_op = 3'd0;
    instr_addr = 8'd0;
    bmem[0] = 16'd7;   bmem[1] = 16'd5;   bmem[2] = 16'd3;   bmem[3] = 16'd100;
    bmem[4] = 16'd9;   bmem[5] = 16'd300; bmem[6] = 16'd0;   bmem[7] = 16'd2;
    bmem[8] = 16'd2;   bmem[9] = 16'd3;   bmem[10] = 16'd4;
    for (int i = 11; i < 16; i++) bmem[i] = 16'(i * 15);
    t_reset();
    t_push_pop();
    t_arith();
    t_divzero();
    t_underflow();
    t_ignored();
    t_handshake();
    t_expr(8'd0, 8'd1, 8'd2, 16'd13);
    t_expr(8'd8, 8'd9, 8'd10, 16'hFFF8);
    bmem[15] = 16'd165;
    t_overflow();
    summary();
    $finish;
  end
endmodule